// File: doc/BRIEF.md
# Timer-Paced Framed Serial DAC Streamer

This block feeds a serial digital-to-analog converter with fixed-width samples at a constant rate. An internal rate timer counts serial clock periods. Each time it expires, the block takes one sample from a valid/ready input and shifts it out most significant bit first. A low-active frame signal covers the whole word. The converter's clock pin is driven with the inverse of the internal serial clock. Data therefore changes on the falling edge of the converter clock and is stable on its rising edge.

A delay flip-flop follows the frame one serial period late, and its output is the converter's load strobe. The strobe drops one serial clock after a word starts. It rises, latching the word into the converter, one serial clock after the word ends. When the timer expires and no sample is offered, the previous word is sent again so the output keeps its rate. A sticky underflow flag records the event.

Control is a three-state machine. ST_IDLE waits for the timer. The transition "start" (timer expiry in ST_IDLE) moves to ST_SHIFT. The transition "last bit" (a serial period boundary with the final bit index) moves to ST_SETTLE. The transition "release" (the next serial period boundary) returns to ST_IDLE. `PERIOD` must be at least `WORD_W + 2`, so that the strobe stays high for at least two serial periods.

Top module: `dac_stream_pacer`

## Requirements
- R1: While rst_n is low: frame_n = 1, load = 1, sdata = 0, dac_clk = 1, underflow = 0, in_ready = 0. A reset also clears a previously set underflow.
- R2: dac_clk is a square wave with a period of 2*HALF_DIV clock cycles. Each level lasts HALF_DIV cycles.
- R3: frame_n falls every PERIOD serial periods (2*HALF_DIV*PERIOD clock cycles). The first fall is visible HALF_DIV + 2*HALF_DIV*(PERIOD-1) clock edges after reset release.
- R4: frame_n stays low for exactly WORD_W serial periods, which contain exactly WORD_W rising edges of dac_clk.
- R5: While frame_n is low, sdata carries the word MSB first, one bit per serial period. sdata changes only in the cycle in which dac_clk falls. sdata is 0 while frame_n is high.
- R6: in_ready is a one-cycle pulse, asserted only in the cycle before frame_n falls. in_data is accepted only when in_valid is high during that pulse. A sample held valid at other times is not consumed.
- R7: If in_valid is low during the in_ready pulse, in_data is ignored. The previously sent word is resent (0 if none since reset), and underflow goes to 1 and stays 1 until reset.
- R8: load falls exactly one serial period after frame_n falls. load rises exactly one serial period after frame_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_data | input | WORD_W | Sample value |
| in_ready | output | 1 | Sample taken on this edge (timer expiry in ST_IDLE) |
| dac_clk | output | 1 | Inverted serial clock for the converter |
| sdata | output | 1 | Serial data, MSB first |
| frame_n | output | 1 | Low for the duration of one word |
| load | output | 1 | Load strobe, frame delayed one serial period |
| underflow | output | 1 | Sticky: a timer expiry found no sample |

## Verification
A word start and the underflow decision happen on the same clock edge. The timer expiry both opens the frame and chooses between the offered sample and the held one. The bench provokes this by dropping in_valid while putting a conspicuous value on in_data across an expiry. It then decodes the serial word and checks that it equals the previously sent word, not the garbage value. It also checks that underflow is already high when that frame closes and that it stays high. With PERIOD at its minimum, the strobe's rise lands one serial period before the next frame start, so the strobe timing is measured against both frame edges.

// File: rtl/dac_stream_pkg.sv
package dac_stream_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_SETTLE = 2'd2
    } stream_state_e;

endpackage

// File: rtl/dac_sclk_gen.sv
// Serial clock generator: divides clk by 2*HALF_DIV and flags the cycle
// before each rising edge of the internal serial clock.
module dac_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk,
    output logic lead
);

    logic flip;

    generate
        if (HALF_DIV <= 1) begin : g_fast
            assign flip = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(HALF_DIV);
            localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);
            logic [DW-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign flip = (div_q == LAST);
        end
    endgenerate

    assign lead = flip && !sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk <= 1'b0;
        end else if (flip) begin
            sclk <= ~sclk;
        end
    end

endmodule

// File: rtl/dac_rate_timer.sv
// Counts serial periods; tick marks the boundary that ends each sample period.
module dac_rate_timer #(
    parameter int PERIOD = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lead,
    output logic tick
);

    localparam int TW = $clog2(PERIOD);
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (lead) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tick = lead && (cnt_q == LAST);

endmodule

// File: rtl/dac_word_shifter.sv
// Parallel-load, left-shifting register with zero fill; msb drives the line.
module dac_word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift_en,
    output logic              msb
);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_en) begin
            sh_q <= load_word;
        end else if (shift_en) begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[WORD_W-1];

endmodule

// File: rtl/dac_strobe_delay.sv
// One serial period of delay on the frame, clocked at serial period boundaries.
module dac_strobe_delay (
    input  logic clk,
    input  logic rst_n,
    input  logic lead,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b1;
        end else if (lead) begin
            q <= d;
        end
    end

endmodule

// File: rtl/dac_stream_pacer.sv
module dac_stream_pacer #(
    parameter int WORD_W   = 16,
    parameter int HALF_DIV = 2,
    parameter int PERIOD   = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              dac_clk,
    output logic              sdata,
    output logic              frame_n,
    output logic              load,
    output logic              underflow
);
    import dac_stream_pkg::*;

    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

    logic              sclk;
    logic              lead;
    logic              tick;
    stream_state_e     state_q;
    stream_state_e     state_d;
    logic [BW-1:0]     bit_q;
    logic [WORD_W-1:0] held_q;
    logic              frame_q;
    logic              uf_q;
    logic              last_bit;
    logic              shift_en;
    logic [WORD_W-1:0] word_pick;

    dac_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .lead  (lead)
    );

    dac_rate_timer #(.PERIOD(PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .lead  (lead),
        .tick  (tick)
    );

    assign in_ready  = tick && (state_q == ST_IDLE);
    assign last_bit  = (bit_q == LAST_BIT);
    assign shift_en  = lead && (state_q == ST_SHIFT);
    assign word_pick = in_valid ? in_data : held_q;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_ready)             state_d = ST_SHIFT;   // start
            ST_SHIFT:  if (lead && last_bit)     state_d = ST_SETTLE;  // last bit
            ST_SETTLE: if (lead)                 state_d = ST_IDLE;    // release
            default:                             state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and per-word bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= 1'b1;
            bit_q   <= '0;
            held_q  <= '0;
            uf_q    <= 1'b0;
        end else if (in_ready) begin
            frame_q <= 1'b0;
            bit_q   <= '0;
            if (in_valid) begin
                held_q <= in_data;
            end else begin
                uf_q <= 1'b1;
            end
        end else if (shift_en) begin
            bit_q <= bit_q + 1'b1;
            if (last_bit) begin
                frame_q <= 1'b1;
            end
        end
    end

    dac_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (in_ready),
        .load_word (word_pick),
        .shift_en  (shift_en),
        .msb       (sdata)
    );

    dac_strobe_delay u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .lead  (lead),
        .d     (frame_q),
        .q     (load)
    );

    assign dac_clk   = ~sclk;
    assign frame_n   = frame_q;
    assign underflow = uf_q;

endmodule

// File: rtl/dac_stream_pacer_chk.sv
module dac_stream_pacer_chk #(
    parameter int WORD_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic dac_clk,
    input logic sdata,
    input logic frame_n,
    input logic load,
    input logic underflow
);

    localparam int CW = $clog2(WORD_W + 1) + 1;

    logic          dac_q;
    logic [CW-1:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_q    <= 1'b1;
            rise_cnt <= '0;
        end else begin
            dac_q <= dac_clk;
            if (frame_n) begin
                rise_cnt <= '0;
            end else if (dac_clk && !dac_q) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // R5
    sdata_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $fell(dac_clk));

    // R4
    frame_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_n) |-> $fell(dac_clk));

    // R4
    frame_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_n) |-> (rise_cnt == CW'(WORD_W)));

    // R8
    load_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load) |-> frame_n);

    // R8
    load_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load) |-> !frame_n);

    // R6
    ready_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (frame_n && load && dac_clk));

    // R6
    ready_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !frame_n);

    // R7
    uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R7
    uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> underflow);

endmodule

bind dac_stream_pacer dac_stream_pacer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .dac_clk   (dac_clk),
    .sdata     (sdata),
    .frame_n   (frame_n),
    .load      (load),
    .underflow (underflow)
);

// File: tb/dac_stream_pacer_tb.sv
module dac_stream_pacer_tb;

    localparam int WORD_W     = 16;
    localparam int HALF_DIV   = 2;
    localparam int PERIOD     = 18;
    localparam int SPER       = 2 * HALF_DIV;
    localparam int FRAME_GAP  = SPER * PERIOD;
    localparam int FIRST_FALL = HALF_DIV + SPER * (PERIOD - 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [WORD_W-1:0] in_data;
    logic              in_ready;
    logic              dac_clk;
    logic              sdata;
    logic              frame_n;
    logic              load;
    logic              underflow;

    always #4 clk = ~clk;

    dac_stream_pacer #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV), .PERIOD(PERIOD)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .dac_clk   (dac_clk),
        .sdata     (sdata),
        .frame_n   (frame_n),
        .load      (load),
        .underflow (underflow)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected words and underflow values, filled by the driver
    logic [WORD_W-1:0] exp_q[$];
    bit                uf_q[$];
    logic [WORD_W-1:0] last_w;
    bit                exp_uf;

    // Edge counter since reset release
    int ecount;
    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    // Monitor
    logic              p_dac, p_frame, p_load, p_sdata, p_ready;
    int                last_dac_fall, last_frame_fall, last_frame_rise;
    logic [WORD_W-1:0] cap;
    int                nbits;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_dac = 1'b1; p_frame = 1'b1; p_load = 1'b1; p_sdata = 1'b0; p_ready = 1'b0;
            last_dac_fall = -1; last_frame_fall = -1; last_frame_rise = -1;
            cap = '0; nbits = 0;
        end else begin
            if (p_dac && !dac_clk) begin
                if (last_dac_fall >= 0)
                    check(ecount - last_dac_fall == SPER, "R2", ecount - last_dac_fall, SPER);
                last_dac_fall = ecount;
            end
            if (!p_dac && dac_clk && !frame_n) begin
                cap = {cap[WORD_W-2:0], sdata};
                nbits++;
            end
            if (sdata !== p_sdata)
                check(p_dac && !dac_clk, "R5", {p_dac, dac_clk}, 2'b10);
            if (frame_n && p_frame)
                check(sdata == 1'b0, "R5", sdata, 0);
            if (p_frame && !frame_n) begin
                if (last_frame_fall < 0)
                    check(ecount == FIRST_FALL, "R3", ecount, FIRST_FALL);
                else
                    check(ecount - last_frame_fall == FRAME_GAP, "R3", ecount - last_frame_fall, FRAME_GAP);
                check(p_ready, "R6", p_ready, 1);
                last_frame_fall = ecount;
                cap = '0;
                nbits = 0;
            end
            if (!p_frame && frame_n) begin
                check(nbits == WORD_W, "R4", nbits, WORD_W);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", cap, 0);
                end else begin
                    logic [WORD_W-1:0] e;
                    bit u;
                    e = exp_q.pop_front();
                    u = uf_q.pop_front();
                    check(cap == e, "R5", cap, e);
                    check(underflow == u, "R7", underflow, u);
                end
                last_frame_rise = ecount;
            end
            if (p_load && !load)
                check(ecount - last_frame_fall == SPER, "R8", ecount - last_frame_fall, SPER);
            if (!p_load && load)
                check(ecount - last_frame_rise == SPER, "R8", ecount - last_frame_rise, SPER);
            if (in_ready && p_ready)
                check(1'b0, "R6", 2, 1);
            p_dac = dac_clk; p_frame = frame_n; p_load = load; p_sdata = sdata; p_ready = in_ready;
        end
    end

    task automatic send(input logic [WORD_W-1:0] w, input bit present);
        in_data  = w;
        in_valid = present;
        do @(negedge clk); while (!in_ready);
        if (present) last_w = w;
        else         exp_uf = 1'b1;
        exp_q.push_back(last_w);
        uf_q.push_back(exp_uf);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
    endtask

    task automatic drain();
        for (int i = 0; i < 4 * FRAME_GAP && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    endtask

    task automatic reset_checks();
        check(frame_n == 1'b1,   "R1", frame_n, 1);
        check(load == 1'b1,      "R1", load, 1);
        check(sdata == 1'b0,     "R1", sdata, 0);
        check(dac_clk == 1'b1,   "R1", dac_clk, 1);
        check(underflow == 1'b0, "R1", underflow, 0);
        check(in_ready == 1'b0,  "R1", in_ready, 0);
    endtask

    function automatic logic [WORD_W-1:0] pat(input int i);
        case (i)
            0:       return 16'h0000;
            1:       return 16'hFFFF;
            2:       return 16'h8000;
            3:       return 16'h0001;
            4:       return 16'hA5A5;
            default: return 16'h5A5A;
        endcase
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        last_w   = '0;
        exp_uf   = 1'b0;
        repeat (3) @(negedge clk);
        reset_checks();
        rst_n = 1'b1;

        // R5: fixed patterns, then walking ones (MSB-first decode)
        for (int i = 0; i < 6; i++) send(pat(i), 1'b1);
        for (int i = 0; i < WORD_W; i++) send(WORD_W'(1) << i, 1'b1);

        // R7: starved ticks with garbage on in_data
        send(16'hDEAD, 1'b0);
        send(16'h3C3C, 1'b1);
        send(16'hBEEF, 1'b0);
        send(16'h0F0F, 1'b1);
        drain();

        // R1: reset clears the sticky flag
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        uf_q.delete();
        last_w = '0;
        exp_uf = 1'b0;
        repeat (2) @(negedge clk);
        reset_checks();
        rst_n = 1'b1;

        // R7: starved first tick resends zero
        send(16'h1234, 1'b0);
        send(16'hC001, 1'b1);
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule